// File: doc/BRIEF.md
# Multi-Channel Transmit FIFO Distributor

This block is a single shared transmit queue that sits between a host write port and up to six serial transmitter data registers. The host pushes 32-bit words in. The block hands them out one at a time, in rotation, to the transmitters that are currently opted in. The rotation runs in ascending channel index and skips any channel whose enable bit is clear. On the way out, each word is cut down to a 24-bit shift-register word. A 3-bit alignment code chooses which input bit becomes the MSB of that word.

The block reports several status values: how many words are stored, which channel will take the next word written, and which channel will take the next word handed out. It also raises a "needs data" flag, set when the number of free entries reaches a programmable watermark. When initialization is enabled, turning the queue on starts an automatic preload. The preload gives one word to every enabled channel without waiting for any request, and a busy flag is high while it runs.

The sequencing is a three-state machine:
- `ST_OFF`: the queue is disabled.
- `ST_PRELOAD`: the automatic first fill is in progress.
- `ST_RUN`: normal operation, where words leave only on request.

Transitions:
- `ST_OFF`→`ST_PRELOAD` when enabled with initialization on and at least one channel enabled.
- `ST_OFF`→`ST_RUN` when enabled in any other case.
- `ST_PRELOAD`→`ST_RUN` when every enabled channel has been loaded, or when initialization is switched off.
- `ST_PRELOAD`→`ST_OFF` and `ST_RUN`→`ST_OFF` when the enable drops.

Top module: `tx_fifo_dist`

## Requirements
- R1: While `cfg_en` is low, host writes are dropped (the count does not change) and no word is handed out, even when `rd_req` is high and words are stored. Stored words are kept while disabled.
- R2: A cycle with `cfg_flush` high clears the stored count to 0, clears the overflow flag and returns both channel pointers to the lowest enabled channel.
- R3: A write while the count equals the depth (default 128) is dropped, and the count stays at the depth. It sets `st_overflow`, which stays high until a flush.
- R4: `st_next_in` gives the channel of the next accepted write. After each accepted write it moves to the next higher enabled channel, wrapping from the highest enabled channel back to the lowest.
- R5: Each handoff sets `out_valid` for one cycle in the cycle after the edge that takes the word. `out_ch` equals the value `st_next_out` had before that handoff, and `st_next_out` then steps through the enabled channels in the same order as in R4.
- R6: `st_count` is the number of stored words. In `ST_RUN` a handoff occurs only when `rd_req` is high, the count is non-zero and at least one channel is enabled. A request while the queue is empty produces no handoff.
- R7: `st_need_data` is high exactly when (depth − `st_count`) ≥ `cfg_wmark`.
- R8: With alignment code N on `cfg_align`, `out_data[23]` is input bit 31−4N and the following 23 bits are the next lower input bits. Codes 0 and 1 drop input bits 7:0 and 3:0. Code 2 passes bits 23:0 unchanged. Codes 3 to 7 fill the low 4N−8 output bits with zero. The code in force at the time of handoff is the one applied.
- R9: Raising `cfg_en` while `cfg_init_en` is high hands one word, without `rd_req`, to each enabled channel in rotation order. `st_init_busy` is high until that preload ends. It is low whenever `cfg_en` or `cfg_init_en` is low.
- R10: If the queue holds fewer words than there are enabled channels during preload, the preload waits with `st_init_busy` high. It resumes as words are written.
- R11: When no channel is enabled, no word is handed out, and `st_next_in` and `st_next_out` both read 0. Writes are still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Queue enable |
| cfg_flush | input | 1 | Clears the count, the pointers and the overflow flag |
| cfg_ch_en | input | NCH (6) | Per-channel participation mask, bit i = channel i |
| cfg_wmark | input | WMW (8) | Free-entry watermark |
| cfg_align | input | 3 | Alignment code N, MSB at input bit 31−4N |
| cfg_init_en | input | 1 | Enable automatic preload when the queue is enabled |
| wr_valid | input | 1 | Host write strobe |
| wr_data | input | DW (32) | Host write word |
| rd_req | input | 1 | Request to hand out one word (`ST_RUN`) |
| out_valid | output | 1 | One-cycle handoff strobe |
| out_ch | output | PW (3) | Channel receiving the handed-out word |
| out_data | output | SW (24) | Aligned word for the channel's data register |
| st_count | output | CW (8) | Number of stored words |
| st_next_in | output | PW (3) | Channel of the next written word |
| st_next_out | output | PW (3) | Channel of the next handed-out word |
| st_need_data | output | 1 | Free entries ≥ watermark |
| st_init_busy | output | 1 | Preload in progress |
| st_overflow | output | 1 | Sticky dropped-write flag |

## Verification
The bench builds the block with its default parameters: 128 entries, six channels, 32-bit input and 24-bit output. A depth of 128 is small enough to fill completely in a few hundred cycles, so the dropped write and sticky overflow at full can be reached directly. With six channels, sparse masks such as channels 1, 3 and 5 are possible, and these test both the skipping of disabled channels and the wrap back to the lowest one. An 8-bit watermark lets the threshold be placed next to a full-depth free count, so the flag can be seen changing between two successive writes.

// File: rtl/tfd_pkg.sv
package tfd_pkg;
    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_PRELOAD = 2'd1,
        ST_RUN     = 2'd2
    } tfd_state_e;
endpackage

// File: rtl/tfd_ring.sv
// Circular word store with read/write pointers and an occupancy count.
module tfd_ring #(
    parameter int DEPTH = 128,
    parameter int DW    = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign rdata = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/tfd_chan_seq.sv
// Tracks a channel pointer that steps through the enabled subset in index order.
module tfd_chan_seq #(
    parameter int NCH = 6,
    localparam int PW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           step,
    input  logic [NCH-1:0] mask,
    output logic [PW-1:0]  cur
);
    logic [PW-1:0] ptr_q;
    logic [PW-1:0] nxt;

    // Lowest enabled channel at or after 'start', with wrap; 0 if none enabled.
    function automatic logic [PW-1:0] scan(input int start, input logic [NCH-1:0] m);
        logic [PW-1:0] r;
        r = '0;
        for (int k = NCH - 1; k >= 0; k--) begin
            int c;
            c = start + k;
            if (c >= NCH) c = c - NCH;
            if (m[c]) r = PW'(c);
        end
        return r;
    endfunction

    assign cur = scan(int'(ptr_q), mask);
    assign nxt = scan(int'(cur) + 1, mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (clear) begin
            ptr_q <= '0;
        end else if (step) begin
            ptr_q <= nxt;
        end
    end
endmodule

// File: rtl/tfd_align.sv
// Selects a SW-bit window whose MSB sits at bit DW-1-4*code, zero-filling below.
module tfd_align #(
    parameter int DW = 32,
    parameter int SW = 24,
    localparam int XW = DW + SW
) (
    input  logic [2:0]    code,
    input  logic [DW-1:0] din,
    output logic [SW-1:0] dout
);
    logic [XW-1:0] wide;
    logic [XW-1:0] moved;
    int            shamt;

    always_comb begin
        wide  = {din, {SW{1'b0}}};
        shamt = DW - 4 * int'(code);
        moved = wide >> shamt;
        dout  = moved[SW-1:0];
    end
endmodule

// File: rtl/tx_fifo_dist.sv
module tx_fifo_dist
    import tfd_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int NCH   = 6,
    parameter int DW    = 32,
    parameter int SW    = 24,
    parameter int WMW   = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int LW   = $clog2(NCH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_en,
    input  logic           cfg_flush,
    input  logic [NCH-1:0] cfg_ch_en,
    input  logic [WMW-1:0] cfg_wmark,
    input  logic [2:0]     cfg_align,
    input  logic           cfg_init_en,
    input  logic           wr_valid,
    input  logic [DW-1:0]  wr_data,
    input  logic           rd_req,
    output logic           out_valid,
    output logic [PW-1:0]  out_ch,
    output logic [SW-1:0]  out_data,
    output logic [CW-1:0]  st_count,
    output logic [PW-1:0]  st_next_in,
    output logic [PW-1:0]  st_next_out,
    output logic           st_need_data,
    output logic           st_init_busy,
    output logic           st_overflow
);
    tfd_state_e    st_q, st_d;
    logic [LW-1:0] loaded_q;
    logic [LW-1:0] need;
    logic          push_go, pop_go, pop_ok, busy;
    logic          full, empty;
    logic [DW-1:0] head;
    logic [SW-1:0] head_al;
    logic          any_ch;

    assign any_ch = |cfg_ch_en;

    always_comb begin
        need = '0;
        for (int i = 0; i < NCH; i++) begin
            need = need + LW'(cfg_ch_en[i]);
        end
    end

    tfd_ring #(.DEPTH(DEPTH), .DW(DW)) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (cfg_flush),
        .push  (push_go),
        .wdata (wr_data),
        .pop   (pop_go),
        .rdata (head),
        .count (st_count),
        .full  (full),
        .empty (empty)
    );

    tfd_chan_seq #(.NCH(NCH)) u_seq_in (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cfg_flush),
        .step  (push_go),
        .mask  (cfg_ch_en),
        .cur   (st_next_in)
    );

    tfd_chan_seq #(.NCH(NCH)) u_seq_out (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cfg_flush),
        .step  (pop_go),
        .mask  (cfg_ch_en),
        .cur   (st_next_out)
    );

    tfd_align #(.DW(DW), .SW(SW)) u_align (
        .code (cfg_align),
        .din  (head),
        .dout (head_al)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF: begin
                if (cfg_en) begin
                    st_d = (cfg_init_en && any_ch) ? ST_PRELOAD : ST_RUN;
                end
            end
            ST_PRELOAD: begin
                if (!cfg_en) begin
                    st_d = ST_OFF;
                end else if (!cfg_init_en || (loaded_q >= need)) begin
                    st_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (!cfg_en) begin
                    st_d = ST_OFF;
                end
            end
            default: st_d = ST_OFF;
        endcase
    end

    // Output / control decode
    always_comb begin
        pop_ok  = !empty && any_ch && !cfg_flush;
        push_go = cfg_en && wr_valid && !full && !cfg_flush;
        pop_go  = 1'b0;
        busy    = 1'b0;
        unique case (st_q)
            ST_OFF: begin
                pop_go = 1'b0;
                busy   = 1'b0;
            end
            ST_PRELOAD: begin
                busy   = cfg_en && cfg_init_en;
                pop_go = busy && (loaded_q < need) && pop_ok;
            end
            ST_RUN: begin
                pop_go = cfg_en && rd_req && pop_ok;
            end
            default: begin
                pop_go = 1'b0;
                busy   = 1'b0;
            end
        endcase
    end

    assign st_init_busy = busy;
    assign st_need_data = ((DEPTH - int'(st_count)) >= int'(cfg_wmark));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            loaded_q <= '0;
        end else if (st_q == ST_OFF) begin
            loaded_q <= '0;
        end else if (pop_go && (st_q == ST_PRELOAD)) begin
            loaded_q <= loaded_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_overflow <= 1'b0;
        end else if (cfg_flush) begin
            st_overflow <= 1'b0;
        end else if (cfg_en && wr_valid && full) begin
            st_overflow <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_ch    <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= pop_go;
            if (pop_go) begin
                out_ch   <= st_next_out;
                out_data <= head_al;
            end
        end
    end
endmodule

// File: rtl/tfd_checker.sv
module tfd_checker #(
    parameter int DEPTH = 128,
    parameter int NCH   = 6,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cfg_en,
    input logic           cfg_flush,
    input logic [NCH-1:0] cfg_ch_en,
    input logic           out_valid,
    input logic [PW-1:0]  out_ch,
    input logic [CW-1:0]  st_count,
    input logic [PW-1:0]  st_next_in,
    input logic [PW-1:0]  st_next_out,
    input logic           st_overflow
);
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_count) <= DEPTH); // R6

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_flush) |-> (st_count == $past(st_count)
                               || st_count == $past(st_count) + 1'b1
                               || st_count + 1'b1 == $past(st_count))); // R6

    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(st_count) != '0); // R6

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_en) |-> !out_valid); // R1

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_flush) |-> (st_count == '0 && !st_overflow)); // R2

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_overflow) && !$past(cfg_flush)) |-> st_overflow); // R3

    AST_IDLE_PTRS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ch_en == '0) |-> (st_next_in == '0 && st_next_out == '0)); // R11

    AST_CH_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((($past(cfg_ch_en) >> out_ch) & NCH'(1)) != '0)); // R5
endmodule

bind tx_fifo_dist tfd_checker #(.DEPTH(DEPTH), .NCH(NCH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_en      (cfg_en),
    .cfg_flush   (cfg_flush),
    .cfg_ch_en   (cfg_ch_en),
    .out_valid   (out_valid),
    .out_ch      (out_ch),
    .st_count    (st_count),
    .st_next_in  (st_next_in),
    .st_next_out (st_next_out),
    .st_overflow (st_overflow)
);

// File: tb/sim_tx_fifo_dist.sv
`timescale 1ns/1ps
module sim_tx_fifo_dist;
    localparam int DEPTH = 128;
    localparam int NCH   = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0, cfg_flush = 1'b0, cfg_init_en = 1'b0;
    logic [5:0]  cfg_ch_en = '0;
    logic [7:0]  cfg_wmark = '0;
    logic [2:0]  cfg_align = 3'd2;
    logic        wr_valid = 1'b0, rd_req = 1'b0;
    logic [31:0] wr_data = '0;
    logic        out_valid;
    logic [2:0]  out_ch, st_next_in, st_next_out;
    logic [23:0] out_data;
    logic [7:0]  st_count;
    logic        st_need_data, st_init_busy, st_overflow;

    int checks = 0;
    int errors = 0;
    int cap_n = 0;
    logic [2:0]  cap_ch [256];
    logic [23:0] cap_d  [256];

    always #2.5 clk = ~clk;

    tx_fifo_dist u0 (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_flush(cfg_flush),
        .cfg_ch_en(cfg_ch_en), .cfg_wmark(cfg_wmark), .cfg_align(cfg_align),
        .cfg_init_en(cfg_init_en), .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_req(rd_req), .out_valid(out_valid), .out_ch(out_ch),
        .out_data(out_data), .st_count(st_count), .st_next_in(st_next_in),
        .st_next_out(st_next_out), .st_need_data(st_need_data),
        .st_init_busy(st_init_busy), .st_overflow(st_overflow)
    );

    always @(negedge clk) begin
        if (out_valid && cap_n < 256) begin
            cap_ch[cap_n] = out_ch;
            cap_d[cap_n]  = out_data;
            cap_n = cap_n + 1;
        end
    end

    // code[58:56] | input[55:24] | expected[23:0]   (R8)
    localparam logic [58:0] VEC [8] = '{
        {3'd0, 32'h89ABCDEF, 24'h89ABCD},
        {3'd1, 32'h89ABCDEF, 24'h9ABCDE},
        {3'd2, 32'h89ABCDEF, 24'hABCDEF},
        {3'd3, 32'h89ABCDEF, 24'hBCDEF0},
        {3'd4, 32'h89ABCDEF, 24'hCDEF00},
        {3'd5, 32'h89ABCDEF, 24'hDEF000},
        {3'd6, 32'h89ABCDEF, 24'hEF0000},
        {3'd7, 32'h89ABCDEF, 24'hF00000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_word(input logic [31:0] d);
        @(negedge clk); wr_valid = 1'b1; wr_data = d;
        @(negedge clk); wr_valid = 1'b0;
        #1;
    endtask

    task automatic pop_one();
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
        #1;
    endtask

    task automatic flush();
        @(negedge clk); cfg_flush = 1'b1;
        @(negedge clk); cfg_flush = 1'b0;
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    task automatic wait_busy_low();
        for (int i = 0; i < 40; i++) begin
            if (!st_init_busy) break;
            @(negedge clk); #1;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors = errors + 1;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // Reset state
        chk("R6 reset count", 32'(st_count), 0);
        chk("R4 reset next_in", 32'(st_next_in), 0);
        chk("R5 reset next_out", 32'(st_next_out), 0);
        chk("R7 reset need_data", 32'(st_need_data), 1);
        chk("R9 reset busy", 32'(st_init_busy), 0);
        chk("R3 reset overflow", 32'(st_overflow), 0);

        // Alignment table (R8), channel 0 only, no preload
        cfg_ch_en = 6'b000001; cfg_en = 1'b1;
        idle(2);
        chk("R9 busy low with init off", 32'(st_init_busy), 0);
        for (int v = 0; v < 8; v++) begin
            cfg_align = VEC[v][58:56];
            base = cap_n;
            write_word(VEC[v][55:24]);
            pop_one();
            chk("R8 handoff count", 32'(cap_n - base), 1);
            chk("R8 aligned data", 32'(cap_d[base]), 32'(VEC[v][23:0]));
        end
        cfg_align = 3'd2;

        // Rotation over channels 1,3,5 (R4, R5)
        @(negedge clk); cfg_ch_en = 6'b101010; #1;
        chk("R4 next_in skips to first enabled", 32'(st_next_in), 1);
        chk("R5 next_out skips to first enabled", 32'(st_next_out), 1);
        write_word(32'h11); chk("R4 next_in after w1", 32'(st_next_in), 3);
        write_word(32'h22); chk("R4 next_in after w2", 32'(st_next_in), 5);
        write_word(32'h33); chk("R4 next_in wraps", 32'(st_next_in), 1);
        chk("R6 count three", 32'(st_count), 3);
        base = cap_n;
        pop_one(); chk("R5 next_out after p1", 32'(st_next_out), 3);
        pop_one(); chk("R5 next_out after p2", 32'(st_next_out), 5);
        pop_one(); chk("R5 next_out wraps", 32'(st_next_out), 1);
        chk("R5 ch0", 32'(cap_ch[base]), 1);
        chk("R5 ch1", 32'(cap_ch[base+1]), 3);
        chk("R5 ch2", 32'(cap_ch[base+2]), 5);
        chk("R5 data order", 32'(cap_d[base+2]), 32'h33);

        // Watermark (R7) then flush (R2)
        @(negedge clk); cfg_wmark = 8'd127; #1;
        chk("R7 free 128", 32'(st_need_data), 1);
        write_word(32'h1); chk("R7 free 127", 32'(st_need_data), 1);
        write_word(32'h2); chk("R7 free 126", 32'(st_need_data), 0);
        chk("R4 next_in before flush", 32'(st_next_in), 5);
        flush();
        chk("R2 count cleared", 32'(st_count), 0);
        chk("R2 next_in reset", 32'(st_next_in), 1);
        chk("R2 next_out reset", 32'(st_next_out), 1);
        cfg_wmark = 8'd0;

        // Empty read (R6)
        base = cap_n;
        pop_one(); idle(1);
        chk("R6 empty read no handoff", 32'(cap_n - base), 0);

        // Disabled (R1)
        write_word(32'h5); write_word(32'h6);
        @(negedge clk); cfg_en = 1'b0;
        write_word(32'h7);
        chk("R1 write dropped while off", 32'(st_count), 2);
        base = cap_n;
        pop_one(); idle(1);
        chk("R1 no handoff while off", 32'(cap_n - base), 0);
        @(negedge clk); cfg_en = 1'b1;
        flush();

        // No channel enabled (R11)
        @(negedge clk); cfg_ch_en = '0;
        write_word(32'h8); write_word(32'h9);
        chk("R11 writes stored", 32'(st_count), 2);
        chk("R11 next_in zero", 32'(st_next_in), 0);
        base = cap_n;
        pop_one(); idle(1);
        chk("R11 no handoff", 32'(cap_n - base), 0);
        chk("R11 next_out zero", 32'(st_next_out), 0);
        flush();

        // Overflow (R3)
        @(negedge clk); cfg_ch_en = 6'b000001; cfg_wmark = 8'd1;
        for (int i = 0; i < DEPTH; i++) write_word(32'(i + 100));
        chk("R6 count full", 32'(st_count), DEPTH);
        chk("R7 full below watermark", 32'(st_need_data), 0);
        chk("R3 no overflow yet", 32'(st_overflow), 0);
        write_word(32'hDEAD);
        chk("R3 count holds at depth", 32'(st_count), DEPTH);
        chk("R3 overflow set", 32'(st_overflow), 1);
        base = cap_n;
        pop_one();
        chk("R3 oldest word kept", 32'(cap_d[base]), 100);
        chk("R3 overflow sticky", 32'(st_overflow), 1);
        flush();
        chk("R2 overflow cleared", 32'(st_overflow), 0);
        cfg_wmark = 8'd0;

        // Preload with stored words (R9)
        @(negedge clk); cfg_ch_en = 6'b000011;
        write_word(32'h00AAAAAA); write_word(32'h00BBBBBB);
        @(negedge clk); cfg_en = 1'b0;
        @(negedge clk); cfg_init_en = 1'b1;
        base = cap_n;
        @(negedge clk); cfg_en = 1'b1;
        @(negedge clk); #1;
        chk("R9 busy after enable", 32'(st_init_busy), 1);
        wait_busy_low();
        chk("R9 busy clears", 32'(st_init_busy), 0);
        chk("R9 preload count", 32'(cap_n - base), 2);
        chk("R9 first to ch0", 32'(cap_ch[base]), 0);
        chk("R9 first data", 32'(cap_d[base]), 32'hAAAAAA);
        chk("R9 second to ch1", 32'(cap_ch[base+1]), 1);
        chk("R9 second data", 32'(cap_d[base+1]), 32'hBBBBBB);
        chk("R9 queue drained", 32'(st_count), 0);

        // Preload stall (R10)
        @(negedge clk); cfg_en = 1'b0;
        #1; chk("R9 busy low when off", 32'(st_init_busy), 0);
        flush();
        @(negedge clk); cfg_ch_en = 6'b000111;
        base = cap_n;
        @(negedge clk); cfg_en = 1'b1;
        idle(5);
        chk("R10 busy while starved", 32'(st_init_busy), 1);
        chk("R10 nothing handed out", 32'(cap_n - base), 0);
        write_word(32'h01); write_word(32'h02); write_word(32'h03);
        wait_busy_low();
        chk("R10 busy clears", 32'(st_init_busy), 0);
        chk("R10 preload count", 32'(cap_n - base), 3);
        chk("R10 ch order 0", 32'(cap_ch[base]), 0);
        chk("R10 ch order 2", 32'(cap_ch[base+2]), 2);
        chk("R10 data order", 32'(cap_d[base+2]), 32'h03);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule